// File: doc/BRIEF.md
# Clock Output Configuration Register Bank

This block keeps the control bytes that a serial management engine writes into a multi-output clock generator, and turns them into the per-output controls the clock tree needs. Software writes whole bytes through a simple port made of a strobe, a 3-bit byte index and 8 data bits. From those bytes the block decodes a global output mode: normal, test, spread on, or all-outputs-released. It picks the active CPU/PCI frequency code either from a board select pin or from register bits. It also applies one enable bit to each output.

A strap pin shared with the first reference output is captured while reset is held. It decides whether the dual-rate fixed output runs at 24 MHz or at 48 MHz. In test mode the block derives divided copies of a slow test clock input, one per output, each gated by that output's enable. The frequency table itself is not part of the block. It appears only as a 3-bit code and a flag saying whether PCI is CPU/2 or CPU/3.

Top module: `clkcfg_bank`

## Requirements
- R1: The mode field is bits [1:0] of byte 0. It decodes 00 as normal, 01 as test (`test_mode_o`=1), 10 as spread on (`spread_on_o`=1) and 11 as release-all. After reset the mode is 00.
- R2: In test mode the test outputs follow the sampled test clock. CPU outputs and the USB output run at TCLK/2, PCI and the free-running PCI output at TCLK/6, and REF and IOAPIC outputs at TCLK. A disabled output stays low. Outside test mode every test output is low.
- R3: Bit 2 of byte 0 is the frequency source and resets to 0. When it is 0 the code comes from `hw_fast_sel_i`: 1 gives code 111 and 0 gives code 011. When it is 1 the code is bits [5:3] of byte 0.
- R4: `pci_div3_o` equals the top bit of the active frequency code: 0 means PCI is CPU/2 and 1 means PCI is CPU/3.
- R5: Bit 6 of byte 0 drives `spread_down_o`: 0 selects center spread and 1 selects down spread. It resets to 0.
- R6: The enable bytes are laid out as follows. Byte 1 holds the CPU enables in bits [3:0]. Byte 2 holds the PCI enables in bits [6:0] and the free-running PCI enable in bit 7. Byte 3 holds REF0..REF2 in bits [2:0] and IOAPIC0..1 in bits [4:3]. A 1 enables the output and a 0 holds it low. Every enable resets to 1 except REF2, which resets to 0.
- R7: `dual_is_24_o` holds the value of `strap_ref0_i` sampled while reset is asserted. Changes on the strap after reset have no effect.
- R8: Reserved bit positions are ignored on write: bit 7 of byte 0, bits [7:4] of byte 1 and bits [7:5] of byte 3.
- R9: A write to a byte index from 4 to 7 is dropped and changes no output.
- R10: In release-all mode `drive_en_o` is 0 and every enable and test output is 0. The stored enable bits are kept, and they reappear when the block leaves that mode.
- R11: A byte write sampled on a clock edge shows at the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Byte write strobe |
| wr_idx_i | input | 3 | Byte index |
| wr_data_i | input | 8 | Byte data |
| hw_fast_sel_i | input | 1 | Board frequency select pin (1 = fast) |
| strap_ref0_i | input | 1 | Strap captured during reset |
| tclk_i | input | 1 | Test clock input (slower than clk) |
| freq_code_o | output | 3 | Active frequency code |
| pci_div3_o | output | 1 | PCI is CPU/3 when 1, CPU/2 when 0 |
| spread_on_o | output | 1 | Spread modulation requested |
| spread_down_o | output | 1 | Down spread when 1, center when 0 |
| test_mode_o | output | 1 | Test mode active |
| drive_en_o | output | 1 | Output drivers enabled |
| dual_is_24_o | output | 1 | Dual-rate output runs at 24 MHz |
| cpu_en_o | output | 4 | CPU output enables |
| pci_en_o | output | 7 | PCI output enables |
| pcif_en_o | output | 1 | Free-running PCI enable |
| ref_en_o | output | 3 | REF output enables |
| apic_en_o | output | 2 | IOAPIC output enables |
| tst_cpu_o | output | 4 | CPU test clocks |
| tst_pci_o | output | 7 | PCI test clocks |
| tst_pcif_o | output | 1 | Free-running PCI test clock |
| tst_ref_o | output | 3 | REF test clocks |
| tst_apic_o | output | 2 | IOAPIC test clocks |
| tst_usb_o | output | 1 | USB test clock |

## Verification
The bench drives the source bit both ways with the board pin toggled. A design that mixed up the source would report the pin's code while register selection is active, or the reverse. It writes all-ones and top-bit-only bytes to catch reserved bits that leak into the mode or code fields. It also writes to an undefined index to catch a decoder that aliases indices 4 to 7 onto real bytes. It enters release-all mode and then leaves it, which exposes a design that clears the stored enables instead of masking them. Finally, it counts test-clock edges over a fixed window, so a wrong divide ratio or a missing enable gate shows up directly, and it changes the strap after reset to catch a latch that keeps following the pin.

// File: rtl/clkcfg_pkg.sv
// Shared constants and types for the clock configuration bank.
// Assumes an 8-bit byte-write port and at most eight byte indices.
package clkcfg_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = 3;
    localparam int CODE_W = 3;

    // Byte indices that the bank decodes; all others are dropped.
    localparam logic [IDX_W-1:0] IDX_FUNC = 3'd0;
    localparam logic [IDX_W-1:0] IDX_CPU  = 3'd1;
    localparam logic [IDX_W-1:0] IDX_PCI  = 3'd2;
    localparam logic [IDX_W-1:0] IDX_REF  = 3'd3;

    // Codes chosen when the board pin drives frequency selection.
    localparam logic [CODE_W-1:0] CODE_FAST = 3'b111;
    localparam logic [CODE_W-1:0] CODE_SLOW = 3'b011;

    typedef enum logic [1:0] {
        MODE_NORM = 2'b00,
        MODE_TEST = 2'b01,
        MODE_SPRD = 2'b10,
        MODE_REL  = 2'b11
    } out_mode_e;

endpackage

// File: rtl/clkcfg_regs.sv
// Register file of the configuration bank. It holds the function byte
// fields, the per-output enables and the power-up strap. It assumes the
// enable counts fit into one byte each (REF + IOAPIC together).
module clkcfg_regs
    import clkcfg_pkg::*;
#(
    parameter int NUM_CPU  = 4,
    parameter int NUM_PCI  = 7,
    parameter int NUM_REF  = 3,
    parameter int NUM_APIC = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [IDX_W-1:0]     wr_idx_i,
    input  logic [BYTE_W-1:0]    wr_data_i,
    input  logic                 strap_i,
    output out_mode_e            mode_o,
    output logic                 freq_src_o,
    output logic [CODE_W-1:0]    freq_reg_o,
    output logic                 spread_down_o,
    output logic [NUM_CPU-1:0]   cpu_en_o,
    output logic [NUM_PCI-1:0]   pci_en_o,
    output logic                 pcif_en_o,
    output logic [NUM_REF-1:0]   ref_en_o,
    output logic [NUM_APIC-1:0]  apic_en_o,
    output logic                 strap_o
);

    localparam int APIC_LO = NUM_REF;
    localparam int APIC_HI = NUM_REF + NUM_APIC - 1;
    // All REF enables set except the last one (REF2 at default width).
    localparam logic [NUM_REF-1:0] REF_RST = {1'b0, {(NUM_REF-1){1'b1}}};

    out_mode_e            mode_q;
    logic                 src_q;
    logic [CODE_W-1:0]    code_q;
    logic                 down_q;
    logic [NUM_CPU-1:0]   cpu_q;
    logic [NUM_PCI-1:0]   pci_q;
    logic                 pcif_q;
    logic [NUM_REF-1:0]   ref_q;
    logic [NUM_APIC-1:0]  apic_q;
    logic                 strap_q;

    logic hit_func, hit_cpu, hit_pci, hit_ref;

    // Decode which byte a write targets; undefined indices match none.
    always_comb begin
        hit_func = wr_en_i && (wr_idx_i == IDX_FUNC);
        hit_cpu  = wr_en_i && (wr_idx_i == IDX_CPU);
        hit_pci  = wr_en_i && (wr_idx_i == IDX_PCI);
        hit_ref  = wr_en_i && (wr_idx_i == IDX_REF);
    end

    // Function byte: mode [1:0], source [2], code [5:3], spread type [6].
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_NORM;
            src_q  <= 1'b0;
            code_q <= '0;
            down_q <= 1'b0;
        end else if (hit_func) begin
            mode_q <= out_mode_e'(wr_data_i[1:0]);
            src_q  <= wr_data_i[2];
            code_q <= wr_data_i[5:3];
            down_q <= wr_data_i[6];
        end
    end

    // CPU enable byte; the upper positions are reserved.
    always_ff @(posedge clk) begin
        if (!rst_n)       cpu_q <= '1;
        else if (hit_cpu) cpu_q <= wr_data_i[NUM_CPU-1:0];
    end

    // PCI enable byte; the top bit is the free-running PCI enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pci_q  <= '1;
            pcif_q <= 1'b1;
        end else if (hit_pci) begin
            pci_q  <= wr_data_i[NUM_PCI-1:0];
            pcif_q <= wr_data_i[BYTE_W-1];
        end
    end

    // REF and IOAPIC enable byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q  <= REF_RST;
            apic_q <= '1;
        end else if (hit_ref) begin
            ref_q  <= wr_data_i[NUM_REF-1:0];
            apic_q <= wr_data_i[APIC_HI:APIC_LO];
        end
    end

    // Strap follows the pin only while reset is held, then freezes.
    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= strap_i;
    end

    assign mode_o        = mode_q;
    assign freq_src_o    = src_q;
    assign freq_reg_o    = code_q;
    assign spread_down_o = down_q;
    assign cpu_en_o      = cpu_q;
    assign pci_en_o      = pci_q;
    assign pcif_en_o     = pcif_q;
    assign ref_en_o      = ref_q;
    assign apic_en_o     = apic_q;
    assign strap_o       = strap_q;

    AST_UNDEF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_idx_i > IDX_REF) |=> ($stable(mode_q) && $stable(code_q)
        && $stable(cpu_q) && $stable(pci_q) && $stable(ref_q) && $stable(apic_q))); // R9

    AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(strap_q)); // R7

    AST_MODE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mode_q == MODE_NORM && !down_q && !src_q)); // R1

endmodule

// File: rtl/clkcfg_freq_sel.sv
// Chooses the active frequency code from the board pin or the register
// field and derives the PCI ratio flag from the code's top bit.
module clkcfg_freq_sel
    import clkcfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 src_reg_i,
    input  logic                 hw_fast_i,
    input  logic [CODE_W-1:0]    code_reg_i,
    output logic [CODE_W-1:0]    code_o,
    output logic                 div3_o
);

    logic [CODE_W-1:0] code_hw;

    // Map the board pin onto one of two fixed codes.
    always_comb code_hw = hw_fast_i ? CODE_FAST : CODE_SLOW;

    // Select the source and derive the ratio flag.
    always_comb begin
        code_o = src_reg_i ? code_reg_i : code_hw;
        div3_o = code_o[CODE_W-1];
    end

    AST_HW_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !src_reg_i |-> (code_o == CODE_FAST || code_o == CODE_SLOW)); // R3

endmodule

// File: rtl/clkcfg_tclk_div.sv
// Divides a sampled test clock by an even ratio DIV. It counts the rising
// edges of the test clock and toggles the output every DIV/2 edges.
// Assumes the test clock is at most a quarter of clk.
module clkcfg_tclk_div #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    output logic clk_o
);

    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic out_q;

    generate
        if (HALF == 1) begin : g_toggle
            // Ratio two: toggle on every test clock rise.
            always_ff @(posedge clk) begin
                if (!rst_n)      out_q <= 1'b0;
                else if (rise_i) out_q <= ~out_q;
            end
        end else begin : g_count
            logic [CW-1:0] cnt_q;
            // Count rises and toggle once HALF of them have passed.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                    out_q <= 1'b0;
                end else if (rise_i) begin
                    if (cnt_q == CW'(HALF - 1)) begin
                        cnt_q <= '0;
                        out_q <= ~out_q;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end
        end
    endgenerate

    assign clk_o = out_q;

    AST_DIV_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_i |=> $stable(out_q)); // R2

endmodule

// File: rtl/clkcfg_out_ctrl.sv
// Applies the decoded mode to the stored enables and to the test clocks.
// Release-all masks everything without touching the stored bits.
module clkcfg_out_ctrl
    import clkcfg_pkg::*;
#(
    parameter int NUM_CPU  = 4,
    parameter int NUM_PCI  = 7,
    parameter int NUM_REF  = 3,
    parameter int NUM_APIC = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  out_mode_e            mode_i,
    input  logic [NUM_CPU-1:0]   cpu_en_i,
    input  logic [NUM_PCI-1:0]   pci_en_i,
    input  logic                 pcif_en_i,
    input  logic [NUM_REF-1:0]   ref_en_i,
    input  logic [NUM_APIC-1:0]  apic_en_i,
    input  logic                 t_div2_i,
    input  logic                 t_div6_i,
    input  logic                 t_raw_i,
    output logic                 test_o,
    output logic                 spread_o,
    output logic                 drive_o,
    output logic [NUM_CPU-1:0]   cpu_en_o,
    output logic [NUM_PCI-1:0]   pci_en_o,
    output logic                 pcif_en_o,
    output logic [NUM_REF-1:0]   ref_en_o,
    output logic [NUM_APIC-1:0]  apic_en_o,
    output logic [NUM_CPU-1:0]   tst_cpu_o,
    output logic [NUM_PCI-1:0]   tst_pci_o,
    output logic                 tst_pcif_o,
    output logic [NUM_REF-1:0]   tst_ref_o,
    output logic [NUM_APIC-1:0]  tst_apic_o,
    output logic                 tst_usb_o
);

    logic rel;
    logic c2, c6, c1;

    // Decode the mode into the global control flags.
    always_comb begin
        rel      = (mode_i == MODE_REL);
        test_o   = (mode_i == MODE_TEST);
        spread_o = (mode_i == MODE_SPRD);
        drive_o  = !rel;
    end

    // Mask the stored enables while every output is released.
    always_comb begin
        cpu_en_o  = rel ? '0 : cpu_en_i;
        pci_en_o  = rel ? '0 : pci_en_i;
        pcif_en_o = rel ? 1'b0 : pcif_en_i;
        ref_en_o  = rel ? '0 : ref_en_i;
        apic_en_o = rel ? '0 : apic_en_i;
    end

    // Gate each divided test clock by test mode and its own enable.
    always_comb begin
        c2 = test_o & t_div2_i;
        c6 = test_o & t_div6_i;
        c1 = test_o & t_raw_i;
        tst_cpu_o  = {NUM_CPU{c2}}  & cpu_en_i;
        tst_pci_o  = {NUM_PCI{c6}}  & pci_en_i;
        tst_pcif_o = c6 & pcif_en_i;
        tst_ref_o  = {NUM_REF{c1}}  & ref_en_i;
        tst_apic_o = {NUM_APIC{c1}} & apic_en_i;
        tst_usb_o  = c2;
    end

    AST_REL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_REL) |-> (!drive_o && cpu_en_o == '0 && pci_en_o == '0
        && ref_en_o == '0 && apic_en_o == '0 && !pcif_en_o)); // R10

    AST_TEST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MODE_TEST) |-> (tst_cpu_o == '0 && tst_pci_o == '0
        && tst_ref_o == '0 && tst_apic_o == '0 && !tst_usb_o && !tst_pcif_o)); // R2

endmodule

// File: rtl/clkcfg_bank.sv
// Top of the clock output configuration bank. It assumes byte writes come
// from an already decoded serial engine in the clk domain and that the
// test clock input is slower than a quarter of clk.
module clkcfg_bank
    import clkcfg_pkg::*;
#(
    parameter int NUM_CPU  = 4,
    parameter int NUM_PCI  = 7,
    parameter int NUM_REF  = 3,
    parameter int NUM_APIC = 2,
    parameter int CPU_TDIV = 2,
    parameter int PCI_TDIV = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [2:0]           wr_idx_i,
    input  logic [7:0]           wr_data_i,
    input  logic                 hw_fast_sel_i,
    input  logic                 strap_ref0_i,
    input  logic                 tclk_i,
    output logic [2:0]           freq_code_o,
    output logic                 pci_div3_o,
    output logic                 spread_on_o,
    output logic                 spread_down_o,
    output logic                 test_mode_o,
    output logic                 drive_en_o,
    output logic                 dual_is_24_o,
    output logic [NUM_CPU-1:0]   cpu_en_o,
    output logic [NUM_PCI-1:0]   pci_en_o,
    output logic                 pcif_en_o,
    output logic [NUM_REF-1:0]   ref_en_o,
    output logic [NUM_APIC-1:0]  apic_en_o,
    output logic [NUM_CPU-1:0]   tst_cpu_o,
    output logic [NUM_PCI-1:0]   tst_pci_o,
    output logic                 tst_pcif_o,
    output logic [NUM_REF-1:0]   tst_ref_o,
    output logic [NUM_APIC-1:0]  tst_apic_o,
    output logic                 tst_usb_o
);

    out_mode_e            mode;
    logic                 src;
    logic [CODE_W-1:0]    code_reg;
    logic [NUM_CPU-1:0]   cpu_st;
    logic [NUM_PCI-1:0]   pci_st;
    logic                 pcif_st;
    logic [NUM_REF-1:0]   ref_st;
    logic [NUM_APIC-1:0]  apic_st;
    logic                 t_q, t_prev, t_rise;
    logic                 t_cpu, t_pci;

    clkcfg_regs #(
        .NUM_CPU(NUM_CPU), .NUM_PCI(NUM_PCI), .NUM_REF(NUM_REF), .NUM_APIC(NUM_APIC)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
        .wr_data_i(wr_data_i), .strap_i(strap_ref0_i), .mode_o(mode),
        .freq_src_o(src), .freq_reg_o(code_reg), .spread_down_o(spread_down_o),
        .cpu_en_o(cpu_st), .pci_en_o(pci_st), .pcif_en_o(pcif_st),
        .ref_en_o(ref_st), .apic_en_o(apic_st), .strap_o(dual_is_24_o)
    );

    clkcfg_freq_sel fsel_i (
        .clk(clk), .rst_n(rst_n), .src_reg_i(src), .hw_fast_i(hw_fast_sel_i),
        .code_reg_i(code_reg), .code_o(freq_code_o), .div3_o(pci_div3_o)
    );

    // Sample the test clock and keep one cycle of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q    <= 1'b0;
            t_prev <= 1'b0;
        end else begin
            t_q    <= tclk_i;
            t_prev <= t_q;
        end
    end

    // Rising edge of the sampled test clock.
    always_comb t_rise = t_q & ~t_prev;

    clkcfg_tclk_div #(.DIV(CPU_TDIV)) div_cpu_i (
        .clk(clk), .rst_n(rst_n), .rise_i(t_rise), .clk_o(t_cpu)
    );

    clkcfg_tclk_div #(.DIV(PCI_TDIV)) div_pci_i (
        .clk(clk), .rst_n(rst_n), .rise_i(t_rise), .clk_o(t_pci)
    );

    clkcfg_out_ctrl #(
        .NUM_CPU(NUM_CPU), .NUM_PCI(NUM_PCI), .NUM_REF(NUM_REF), .NUM_APIC(NUM_APIC)
    ) octl_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .cpu_en_i(cpu_st), .pci_en_i(pci_st), .pcif_en_i(pcif_st),
        .ref_en_i(ref_st), .apic_en_i(apic_st),
        .t_div2_i(t_cpu), .t_div6_i(t_pci), .t_raw_i(t_q),
        .test_o(test_mode_o), .spread_o(spread_on_o), .drive_o(drive_en_o),
        .cpu_en_o(cpu_en_o), .pci_en_o(pci_en_o), .pcif_en_o(pcif_en_o),
        .ref_en_o(ref_en_o), .apic_en_o(apic_en_o),
        .tst_cpu_o(tst_cpu_o), .tst_pci_o(tst_pci_o), .tst_pcif_o(tst_pcif_o),
        .tst_ref_o(tst_ref_o), .tst_apic_o(tst_apic_o), .tst_usb_o(tst_usb_o)
    );

    AST_RATIO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (src && !code_reg[CODE_W-1]) |-> !pci_div3_o); // R4

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_idx_i == IDX_CPU) |=> (cpu_st == $past(wr_data_i[NUM_CPU-1:0]))); // R11

endmodule

// File: tb/clkcfg_bank_tb.sv
module clkcfg_bank_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_idx = '0;
    logic [7:0] wr_data = '0;
    logic       hw_fast = 1'b1;
    logic       strap = 1'b1;
    logic       tclk = 1'b0;

    logic [2:0] freq_code;
    logic       div3, sp_on, sp_down, tmode, drv, dual24;
    logic [3:0] cpu_en;
    logic [6:0] pci_en;
    logic       pcif_en;
    logic [2:0] ref_en;
    logic [1:0] apic_en;
    logic [3:0] tst_cpu;
    logic [6:0] tst_pci;
    logic       tst_pcif;
    logic [2:0] tst_ref;
    logic [1:0] tst_apic;
    logic       tst_usb;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    clkcfg_bank dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
        .wr_data_i(wr_data), .hw_fast_sel_i(hw_fast), .strap_ref0_i(strap),
        .tclk_i(tclk), .freq_code_o(freq_code), .pci_div3_o(div3),
        .spread_on_o(sp_on), .spread_down_o(sp_down), .test_mode_o(tmode),
        .drive_en_o(drv), .dual_is_24_o(dual24), .cpu_en_o(cpu_en),
        .pci_en_o(pci_en), .pcif_en_o(pcif_en), .ref_en_o(ref_en),
        .apic_en_o(apic_en), .tst_cpu_o(tst_cpu), .tst_pci_o(tst_pci),
        .tst_pcif_o(tst_pcif), .tst_ref_o(tst_ref), .tst_apic_o(tst_apic),
        .tst_usb_o(tst_usb)
    );

    // Test clock: period of four clk cycles, driven away from the edge.
    always begin
        @(negedge clk); @(negedge clk);
        tclk = ~tclk;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            n_chk = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        rst_n = 1'b0; strap = s;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Rise counts over a 96-cycle window (24 test clock periods).
    int r_cpu0, r_cpu1, r_pci0, r_pcif, r_ref2, r_ref0, r_apic0, r_usb;
    task automatic count_window();
        logic [7:0] prev, cur;
        r_cpu0 = 0; r_cpu1 = 0; r_pci0 = 0; r_pcif = 0;
        r_ref2 = 0; r_ref0 = 0; r_apic0 = 0; r_usb = 0;
        @(negedge clk);
        prev = {tst_cpu[0], tst_cpu[1], tst_pci[0], tst_pcif, tst_ref[2], tst_ref[0], tst_apic[0], tst_usb};
        for (int i = 0; i < 96; i++) begin
            @(negedge clk);
            cur = {tst_cpu[0], tst_cpu[1], tst_pci[0], tst_pcif, tst_ref[2], tst_ref[0], tst_apic[0], tst_usb};
            if (cur[7] && !prev[7]) r_cpu0++;
            if (cur[6] && !prev[6]) r_cpu1++;
            if (cur[5] && !prev[5]) r_pci0++;
            if (cur[4] && !prev[4]) r_pcif++;
            if (cur[3] && !prev[3]) r_ref2++;
            if (cur[2] && !prev[2]) r_ref0++;
            if (cur[1] && !prev[1]) r_apic0++;
            if (cur[0] && !prev[0]) r_usb++;
            prev = cur;
        end
    endtask

    // Function byte vectors: data, hw pin, code, div3, spread on, down, test, drive.
    localparam int NV = 9;
    localparam logic [16:0] VEC [NV] = '{
        {8'h00, 1'b1, 3'b111, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'h00, 1'b0, 3'b011, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'h04, 1'b1, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'h2C, 1'b0, 3'b101, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'h02, 1'b1, 3'b111, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
        {8'h41, 1'b0, 3'b011, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
        {8'h03, 1'b1, 3'b111, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'hFF, 1'b0, 3'b111, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'h80, 1'b0, 3'b011, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}
    };

    initial begin
        do_reset(1'b1);
        // Reset state.
        chk("R1 reset mode test", 32'(tmode), 0);
        chk("R1 reset mode spread", 32'(sp_on), 0);
        chk("R1 reset drive", 32'(drv), 1);
        chk("R3 reset source uses pin", 32'(freq_code), 32'h7);
        chk("R5 reset spread type", 32'(sp_down), 0);
        chk("R6 reset cpu", 32'(cpu_en), 32'hF);
        chk("R6 reset pci", 32'(pci_en), 32'h7F);
        chk("R6 reset pcif", 32'(pcif_en), 1);
        chk("R6 reset ref", 32'(ref_en), 32'h3);
        chk("R6 reset apic", 32'(apic_en), 32'h3);
        chk("R7 strap high", 32'(dual24), 1);
        strap = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 strap ignored after reset", 32'(dual24), 1);

        // Vector walk over the function byte.
        for (int v = 0; v < NV; v++) begin
            hw_fast = VEC[v][8];
            wr(3'd0, VEC[v][16:9]);
            chk("R3 code", 32'(freq_code), 32'(VEC[v][7:5]));
            chk("R4 ratio", 32'(div3), 32'(VEC[v][4]));
            chk("R1 spread on", 32'(sp_on), 32'(VEC[v][3]));
            chk("R5 spread down", 32'(sp_down), 32'(VEC[v][2]));
            chk("R1 test mode", 32'(tmode), 32'(VEC[v][1]));
            chk("R8 R11 drive", 32'(drv), 32'(VEC[v][0]));
        end

        // Enable bytes with reserved bits set.
        wr(3'd1, 8'hF5);
        chk("R8 R11 cpu enables", 32'(cpu_en), 32'h5);
        wr(3'd2, 8'h55);
        chk("R6 pci enables", 32'(pci_en), 32'h55);
        chk("R6 pcif enable", 32'(pcif_en), 0);
        wr(3'd3, 8'hE4);
        chk("R8 ref enables", 32'(ref_en), 32'h4);
        chk("R8 apic enables", 32'(apic_en), 32'h0);

        // Undefined index.
        wr(3'd5, 8'h00);
        wr(3'd7, 8'h03);
        chk("R9 cpu unchanged", 32'(cpu_en), 32'h5);
        chk("R9 pci unchanged", 32'(pci_en), 32'h55);
        chk("R9 ref unchanged", 32'(ref_en), 32'h4);
        chk("R9 mode unchanged", 32'(drv), 1);

        // Release-all and back.
        wr(3'd0, 8'h03);
        chk("R10 drive off", 32'(drv), 0);
        chk("R10 cpu masked", 32'(cpu_en), 0);
        chk("R10 pci masked", 32'(pci_en), 0);
        chk("R10 ref masked", 32'(ref_en), 0);
        wr(3'd0, 8'h00);
        chk("R10 pci restored", 32'(pci_en), 32'h55);
        chk("R10 cpu restored", 32'(cpu_en), 32'h5);

        // Test mode divides.
        wr(3'd0, 8'h01);
        repeat (8) @(negedge clk);
        count_window();
        chk("R2 cpu0 TCLK/2", 32'(r_cpu0), 12);
        chk("R2 cpu1 disabled low", 32'(r_cpu1), 0);
        chk("R2 pci0 TCLK/6", 32'(r_pci0), 4);
        chk("R2 pcif disabled low", 32'(r_pcif), 0);
        chk("R2 ref2 TCLK", 32'(r_ref2), 24);
        chk("R2 ref0 disabled low", 32'(r_ref0), 0);
        chk("R2 apic disabled low", 32'(r_apic0), 0);
        chk("R2 usb TCLK/2", 32'(r_usb), 12);
        wr(3'd3, 8'h1B);
        count_window();
        chk("R2 apic0 TCLK", 32'(r_apic0), 24);
        wr(3'd0, 8'h00);
        count_window();
        chk("R2 ref2 low outside test", 32'(r_ref2), 0);
        chk("R2 usb low outside test", 32'(r_usb), 0);

        // Strap low on a new reset.
        do_reset(1'b0);
        chk("R7 strap low", 32'(dual24), 0);
        chk("R6 ref after reset", 32'(ref_en), 32'h3);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule